// File: doc/BRIEF.md
# Indexed Chipset Configuration Register Port

This block is the software-visible face of a memory-controller configuration space. Software reaches it through four consecutive byte ports. Offset 0 is a data window into a table of page-mapping entries, selected by a mapping index held at offset 2. Offset 1 holds a pointer to a configuration register, and offset 3 is the data window that the pointer selects. Seven configuration registers sit behind that window. Their values drive the address-translation and decode logic continuously, through a flat output bus.

The silicon revision is a build parameter, and it changes what software sees. On revision 0 the configuration pointer cannot be moved. The upper nibble of register 4 always reports the revision and cannot be written. Register 6 exists only on revision 8. Two strap inputs describe the installed memory: a 3-bit size code that fills the top of register 0, and a flag for more than 8 MB that appears as bit 0 of register 6.

A write that can change the memory map raises `remap` for one cycle. That includes any mapping-entry write. A 16-bit access at offset N acts as two byte accesses: the low byte goes to N and the high byte to N+1.

Top module: `cfg_port`

## Requirements
- R1: After reset, the pointer is 0, the mapping index is 0, every mapping entry is 0, register 0 is 0x04, register 4 is {REV,4'h0}, the other registers are 0, `io_rdata` is 0 and `remap` is low.
- R2: `io_port` selects the target: 0 is mapping data, 1 is the configuration pointer, 2 is the mapping index and 3 is configuration data. A read loads `io_rdata` at the clock edge. `io_rdata` then holds until the next read. A read returns the values from before any write made in the same cycle.
- R3: On revision 0, writes to offset 1 are ignored and reads of offset 1 return 0xFF. On other revisions offset 1 reads back the stored pointer.
- R4: A write to register 0 stores data bits [4:0] in bits [4:0]. It stores `mem_code` in bits [7:5].
- R5: Bits [7:4] of register 4 always equal REV. A write to register 4 changes only bits [3:0].
- R6: On revision 8, a write to register 6 stores bits [7:1]. Bit 0 of register 6 always shows `mem_big`. On other revisions register 6 is 0x00.
- R7: When the pointer is 7 or more, configuration data reads return 0xFF and writes change nothing. Registers 1, 2, 3 and 5 are plain 8-bit storage.
- R8: With `io_wide` set at offset 3, the high byte falls outside the port range. Its write is dropped and it reads as 0xFF.
- R9: `remap` is high for exactly the cycle after a write that reaches mapping data, register 0, register 4, or register 6 on revision 8. It stays low after any other write.
- R10: With `io_wide` set, byte [7:0] goes to offset N and byte [15:8] goes to offset N+1. A read returns {byte at N+1, byte at N}. A narrow read puts 0xFF in bits [15:8].
- R11: A mapping-data write stores into the entry selected by the low log2(MAP_DEPTH) bits of the mapping index. `map_val` shows that entry and `map_idx` shows the full stored index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe, one access per asserted cycle |
| io_rd | input | 1 | Read strobe |
| io_wide | input | 1 | 16-bit access covering offsets N and N+1 |
| io_port | input | 2 | Port offset N |
| io_wdata | input | 16 | Write data, low byte for offset N |
| io_rdata | output | 16 | Registered read data |
| mem_code | input | 3 | Memory-size code copied into register 0 bits [7:5] |
| mem_big | input | 1 | Installed memory above 8 MB |
| cfg_q | output | 56 | Registers 0 to 6, register i at bits [8i+7:8i] |
| map_idx | output | 8 | Stored mapping index |
| map_val | output | 8 | Mapping entry under the index |
| remap | output | 1 | Memory map must be re-evaluated |

## Verification
The checker assumes that reset is held long enough for `io_wr` and `io_rd` to be low at the first active edge. It assumes that the strap inputs change only between accesses, never during one. Its write properties look only at narrow accesses, or at the offset-3 byte of a wide access. They also assume the pointer was settled by an earlier cycle. The stimulus drives every input on the falling edge, moves the straps only between operations, and mixes random widths, offsets and data with directed pointer values such as 4, 6 and 7. Both revision 8 and revision 0 instances see the same traffic.

// File: rtl/cfg_port.sv
module cfg_port #(
  parameter int REV       = 8,
  parameter int MAP_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic        io_wide,
  input  logic [1:0]  io_port,
  input  logic [15:0] io_wdata,
  output logic [15:0] io_rdata,
  input  logic [2:0]  mem_code,
  input  logic        mem_big,
  output logic [55:0] cfg_q,
  output logic [7:0]  map_idx,
  output logic [7:0]  map_val,
  output logic        remap
);
  localparam int NREG = 7;
  localparam int IW = $clog2(MAP_DEPTH);
  localparam logic [3:0] REVN = 4'(REV);
  localparam bit HAS_R6 = (REV == 8);

  logic [7:0] cr [NREG];
  logic [7:0] cfg_idx, map_ix;
  logic [7:0] map_mem [MAP_DEPTH];
  logic [3:0] hit;
  logic [7:0] wb [4];
  logic [7:0] cfg_rd;
  logic       map_touch;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      hit[k] = io_wr && ((io_port == 2'(k)) ||
               (io_wide && ({1'b0, io_port} + 3'd1 == 3'(k))));
      wb[k]  = (io_port == 2'(k)) ? io_wdata[7:0] : io_wdata[15:8];
    end
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) cfg_q[i*8 +: 8] = cr[i];
    cfg_q[55:48] = HAS_R6 ? {cr[6][7:1], mem_big} : 8'h00;
  end

  assign cfg_rd  = (cfg_idx < 8'(NREG)) ? cfg_q[cfg_idx[2:0]*8 +: 8] : 8'hFF;
  assign map_idx = map_ix;
  assign map_val = map_mem[map_ix[IW-1:0]];
  assign map_touch = hit[0] || (hit[3] && (cfg_idx == 8'd0 || cfg_idx == 8'd4 ||
                                           (HAS_R6 && cfg_idx == 8'd6)));

  function automatic logic [7:0] rd_byte(input logic [2:0] off);
    case (off)
      3'd0:    rd_byte = map_val;
      3'd1:    rd_byte = (REV == 0) ? 8'hFF : cfg_idx;
      3'd2:    rd_byte = map_ix;
      3'd3:    rd_byte = cfg_rd;
      default: rd_byte = 8'hFF;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cr[i] <= 8'h00;
      cr[0] <= 8'h04;
      cr[4] <= {REVN, 4'h0};
      for (int j = 0; j < MAP_DEPTH; j++) map_mem[j] <= 8'h00;
      cfg_idx  <= 8'h00;
      map_ix   <= 8'h00;
      io_rdata <= 16'h0000;
      remap    <= 1'b0;
    end else begin
      remap <= map_touch;
      if (io_rd)
        io_rdata <= {io_wide ? rd_byte({1'b0, io_port} + 3'd1) : 8'hFF,
                     rd_byte({1'b0, io_port})};
      if (hit[0]) map_mem[map_ix[IW-1:0]] <= wb[0];
      if (hit[1] && REV != 0) cfg_idx <= wb[1];
      if (hit[2]) map_ix <= wb[2];
      if (hit[3]) begin
        case (cfg_idx)
          8'd0: cr[0] <= {mem_code, wb[3][4:0]};
          8'd4: cr[4] <= {REVN, wb[3][3:0]};
          8'd6: if (HAS_R6) cr[6] <= {wb[3][7:1], 1'b0};
          8'd1, 8'd2, 8'd3, 8'd5: cr[cfg_idx[2:0]] <= wb[3];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int REV = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic        io_rd,
  input logic [1:0]  io_port,
  input logic [15:0] io_wdata,
  input logic [15:0] io_rdata,
  input logic [2:0]  mem_code,
  input logic        mem_big,
  input logic [55:0] cfg_q,
  input logic [7:0]  map_val,
  input logic [7:0]  cfg_idx,
  input logic        remap
);
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  p_idx_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_port == 2'd1) |=>
      io_rdata[7:0] == ((REV == 0) ? 8'hFF : $past(cfg_idx)));

  p_cr0_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port == 2'd3 && cfg_idx == 8'd0) |=>
      cfg_q[7:0] == {$past(mem_code), $past(io_wdata[4:0])});

  p_cr4_rev_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[39:36] == 4'(REV));

  p_cr6_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (REV == 8) ? (cfg_q[48] == mem_big) : (cfg_q[55:48] == 8'h00));

  p_remap_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    remap |-> $past(io_wr));

  p_map_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port == 2'd0) |=> map_val == $past(io_wdata[7:0]));
endmodule

bind cfg_port cfg_port_chk #(.REV(REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_code(mem_code),
  .mem_big(mem_big), .cfg_q(cfg_q), .map_val(map_val), .cfg_idx(cfg_idx),
  .remap(remap)
);

// File: tb/sim_cfg_port.sv
module sim_cfg_port;
  logic clk = 0, rst_n = 0;
  logic io_wr = 0, io_rd = 0, io_wide = 0;
  logic [1:0] io_port = 0;
  logic [15:0] io_wdata = 0;
  logic [2:0] mem_code = 3'd5;
  logic mem_big = 0;
  logic [15:0] rdata [2];
  logic [55:0] cfgq [2];
  logic [7:0] mix [2], mval [2];
  logic remap [2];

  always #4 clk = ~clk;

  cfg_port #(.REV(8)) u0 (.clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_wide(io_wide), .io_port(io_port), .io_wdata(io_wdata), .io_rdata(rdata[0]),
    .mem_code(mem_code), .mem_big(mem_big), .cfg_q(cfgq[0]), .map_idx(mix[0]),
    .map_val(mval[0]), .remap(remap[0]));
  cfg_port #(.REV(0)) u1 (.clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_wide(io_wide), .io_port(io_port), .io_wdata(io_wdata), .io_rdata(rdata[1]),
    .mem_code(mem_code), .mem_big(mem_big), .cfg_q(cfgq[1]), .map_idx(mix[1]),
    .map_val(mval[1]), .remap(remap[1]));

  int checks = 0, fails = 0;
  bit done = 0;
  int revs [2] = '{8, 0};
  logic [7:0] m_cr [2][7];
  logic [7:0] m_idx [2], m_mix [2];
  logic [7:0] m_map [2][64];
  logic [15:0] e_rd [2];
  logic e_rm [2];

  task automatic chk(string tag, int d, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s dev%0d actual=%h expected=%h", tag, d, act, exp);
    end
  endtask

  function automatic logic [7:0] cr_out(int d, int i);
    if (i == 6) return (revs[d] == 8) ? {m_cr[d][6][7:1], mem_big} : 8'h00;
    return m_cr[d][i];
  endfunction

  function automatic logic [55:0] cfg_exp(int d);
    logic [55:0] v;
    for (int i = 0; i < 7; i++) v[i*8 +: 8] = cr_out(d, i);
    return v;
  endfunction

  function automatic logic [7:0] m_rb(int d, int off);
    case (off)
      0: return m_map[d][m_mix[d][5:0]];
      1: return (revs[d] == 0) ? 8'hFF : m_idx[d];
      2: return m_mix[d];
      3: return (m_idx[d] < 7) ? cr_out(d, int'(m_idx[d])) : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic m_wb(int d, int off, logic [7:0] b);
    case (off)
      0: m_map[d][m_mix[d][5:0]] = b;
      1: if (revs[d] != 0) m_idx[d] = b;
      2: m_mix[d] = b;
      3: case (m_idx[d])
           8'd0: m_cr[d][0] = {mem_code, b[4:0]};
           8'd4: m_cr[d][4] = {4'(revs[d]), b[3:0]};
           8'd6: if (revs[d] == 8) m_cr[d][6] = {b[7:1], 1'b0};
           8'd1, 8'd2, 8'd3, 8'd5: m_cr[d][m_idx[d]] = b;
           default: ;
         endcase
      default: ;
    endcase
  endtask

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 7; i++) m_cr[d][i] = 8'h00;
      m_cr[d][0] = 8'h04;
      m_cr[d][4] = {4'(revs[d]), 4'h0};
      m_idx[d] = 0; m_mix[d] = 0; e_rd[d] = 0;
      for (int j = 0; j < 64; j++) m_map[d][j] = 0;
    end
  endtask

  task automatic check_all(string tag);
    for (int d = 0; d < 2; d++) begin
      chk(tag, d, 64'(rdata[d]), 64'(e_rd[d]));
      chk(tag, d, 64'(remap[d]), 64'(e_rm[d]));
      chk(tag, d, 64'(cfgq[d]), 64'(cfg_exp(d)));
      chk(tag, d, 64'(mix[d]), 64'(m_mix[d]));
      chk(tag, d, 64'(mval[d]), 64'(m_map[d][m_mix[d][5:0]]));
    end
  endtask

  task automatic op(string tag, bit wr, bit rd, bit wide, int port, logic [15:0] data);
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_wide = wide; io_port = 2'(port); io_wdata = data;
    for (int d = 0; d < 2; d++) begin
      if (rd) e_rd[d] = {wide ? m_rb(d, port + 1) : 8'hFF, m_rb(d, port)};
      e_rm[d] = 0;
      if (wr) begin
        if (port == 0 || (wide && port + 1 == 0)) e_rm[d] = 1;
        if ((port == 3 || (wide && port + 1 == 3)) &&
            (m_idx[d] == 0 || m_idx[d] == 4 || (m_idx[d] == 6 && revs[d] == 8)))
          e_rm[d] = 1;
      end
    end
    if (wr)
      for (int d = 0; d < 2; d++) begin
        logic [7:0] pi = m_idx[d];
        logic [7:0] pm = m_mix[d];
        m_wb(d, port, data[7:0]);
        if (wide) begin
          if (port + 1 == 3) m_idx[d] = pi;
          m_mix[d] = (port + 1 == 0) ? pm : m_mix[d];
          m_wb(d, port + 1, data[15:8]);
        end
      end
    @(negedge clk);
    check_all(tag);
    io_wr = 0; io_rd = 0; io_wide = 0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    e_rm[0] = 0; e_rm[1] = 0;
    @(negedge clk);
    check_all("R1");

    op("R3", 1, 0, 0, 1, 16'h0004);
    op("R3", 0, 1, 0, 1, 16'h0000);
    op("R4", 1, 0, 0, 1, 16'h0000);
    mem_code = 3'd6;
    op("R4", 1, 0, 0, 3, 16'hFFEB);
    op("R4", 0, 1, 0, 3, 16'h0000);
    op("R5", 1, 0, 0, 1, 16'h0004);
    op("R5", 1, 0, 0, 3, 16'h00F5);
    op("R5", 0, 1, 0, 3, 16'h0000);
    op("R6", 1, 0, 0, 1, 16'h0006);
    op("R6", 1, 0, 0, 3, 16'h00A7);
    mem_big = 1;
    op("R6", 0, 1, 0, 3, 16'h0000);
    op("R9", 1, 0, 0, 1, 16'h0002);
    op("R9", 1, 0, 0, 3, 16'h005A);
    op("R7", 1, 0, 0, 1, 16'h0007);
    op("R7", 1, 0, 0, 3, 16'h0033);
    op("R7", 0, 1, 0, 3, 16'h0000);
    op("R8", 1, 1, 1, 3, 16'h9911);
    op("R11", 1, 0, 0, 2, 16'h00C5);
    op("R11", 1, 0, 0, 0, 16'h003C);
    op("R11", 0, 1, 0, 0, 16'h0000);
    op("R10", 1, 0, 1, 2, 16'h0185);
    op("R10", 0, 1, 1, 0, 16'h0000);
    op("R10", 0, 1, 1, 2, 16'h0000);
    op("R2", 1, 1, 1, 1, 16'h4103);

    for (int n = 0; n < 3000; n++) begin
      int port;
      logic [15:0] data;
      if ($urandom_range(0, 15) == 0) mem_code = 3'($urandom);
      if ($urandom_range(0, 15) == 0) mem_big = 1'($urandom);
      port = $urandom_range(0, 3);
      data = 16'($urandom);
      if (port == 1 || (port == 0 && $urandom_range(0, 1) == 1))
        data[7:0] = 8'($urandom_range(0, 8));
      op("R2", 1'($urandom), 1'($urandom), 1'($urandom), port, data);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule